// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sequences the power modes of a small microcontroller. The CPU raises a one-cycle wait or stop request; the block masks nothing in response, but instead clears the interrupt mask and switches the CPU clock off. In wait the clock generator keeps running, and any enabled wake source brings the CPU back in the next cycle. In stop, the behaviour depends on a configuration input sampled when stop is entered.

When the hold-oscillator configuration bit is low, stop shuts the clock generator down. All four derived clock enables drop, the two oscillator-stable flags are cleared, and the clock monitor is switched off, which also clears its interrupt enable and its flag. The generator settings word is left as it was. On wake-up the CPU clock stays off for a settling interval (4096 cycles by default) before the block returns to run mode. When the bit is high, the generator keeps running through stop, the timebase tick can wake the chip at once, and there is no settling interval. In neither case can a clock-generator interrupt end stop. A debug (break) interrupt ends stop and raises a sticky break-in-stop flag.

The oscillator, the multiplier and the CPU core lie outside the block. Simple ready, fault and write strobes stand in for them.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: In run mode (mode code 0), a stop request moves the block to stop (code 2) and a wait request moves it to wait (code 1). Stop takes priority when both are raised together. In the cycle after the request, cpu_clk_en is 0 and irq_mask is 0.
- R2: Reset gives mode 0, irq_mask 1, cpu_clk_en 1, every clk_en bit 1, and all flags, monitor bits and settings at 0. Leaving wait or stop through an interrupt leaves irq_mask at 0.
- R3: In wait, ext_irq, tick_irq, dbg_irq, or gen_irq while gen_irq_en is 1, returns the block to run in the next cycle. gen_irq while gen_irq_en is 0 has no effect.
- R4: After a stop entered with osc_hold_cfg 0, every clk_en bit is 0 from the next cycle until run mode is reached again.
- R5: Entering stop with osc_hold_cfg 0 clears xtal_stable, rc_stable, mon_en, mon_irq_en and mon_flag. gen_settings is unchanged.
- R6: In a stop entered with osc_hold_cfg 1, every clk_en bit stays 1, the stable and monitor bits are kept, and tick_irq returns the block to run in the next cycle with no settling interval.
- R7: In stop, gen_irq never wakes the block. tick_irq wakes it only when osc_hold_cfg was 1 at entry.
- R8: dbg_irq in stop wakes the block and sets dbg_stop_flag. Entering stop does not change the flag. dbg_irq outside stop does not set it. dbg_flag_clr in run mode clears it.
- R9: A wake from a stop entered with osc_hold_cfg 0 passes through the settling state (code 3) for exactly SETTLE_CYCLES cycles, with cpu_clk_en 0 throughout, before run resumes.
- R10: xtal_ready and rc_ready set their sticky stable flags. A monitor write loads mon_en from mon_wdata bit 0 and mon_irq_en from bit 1 ANDed with bit 0, and it clears mon_flag. mon_fault sets mon_flag only while mon_en is 1. Writes take effect only in run mode.
- R11: mask_wr loads irq_mask from mask_wdata only in run mode. In wait or stop, mask_wr is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_req | input | 1 | Wait request strobe |
| stop_req | input | 1 | Stop request strobe |
| osc_hold_cfg | input | 1 | Keep generator running in stop, sampled at entry |
| ext_irq | input | 1 | External interrupt |
| gen_irq | input | 1 | Clock-generator interrupt |
| gen_irq_en | input | 1 | Clock-generator interrupt enable |
| tick_irq | input | 1 | Timebase interrupt |
| dbg_irq | input | 1 | Break interrupt |
| mask_wr | input | 1 | Interrupt-mask write strobe |
| mask_wdata | input | 1 | Interrupt-mask write value |
| dbg_flag_clr | input | 1 | Clear break-in-stop flag |
| xtal_ready | input | 1 | External oscillator stable pulse |
| rc_ready | input | 1 | Internal oscillator stable pulse |
| set_wr | input | 1 | Settings write strobe |
| set_wdata | input | SET_W | Settings write value |
| mon_wr | input | 1 | Monitor control write strobe |
| mon_wdata | input | 2 | Bit 0 monitor enable, bit 1 monitor interrupt enable |
| mon_fault | input | 1 | Clock fault seen by the monitor |
| cpu_clk_en | output | 1 | CPU clock enable |
| clk_en | output | NCLK | Derived clock enables: system, bus, watchdog, timebase |
| irq_mask | output | 1 | Interrupt mask bit |
| dbg_stop_flag | output | 1 | Break-in-stop flag |
| xtal_stable | output | 1 | External oscillator stable flag |
| rc_stable | output | 1 | Internal oscillator stable flag |
| mon_en | output | 1 | Clock monitor enable |
| mon_irq_en | output | 1 | Clock monitor interrupt enable |
| mon_flag | output | 1 | Clock monitor flag |
| gen_settings | output | SET_W | Generator settings word |
| mode | output | 2 | Mode: 0 run, 1 wait, 2 stop, 3 settling |

## Verification
Every output comes from registered state. A request, wake source or write that is held across a rising edge therefore shows on the outputs one cycle later. The exception is the return from settling, which comes SETTLE_CYCLES cycles after the wake edge. The bench changes inputs on the falling edge and keeps a behavioural model that advances on each rising edge. It compares every output at the next falling edge, so each result is sampled in the first cycle in which it is due. The directed checks count falling edges from the wake stimulus to confirm the length of the settling interval.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        M_RUN    = 2'd0,
        M_WAIT   = 2'd1,
        M_STOP   = 2'd2,
        M_SETTLE = 2'd3
    } pmode_e;
endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wait_req,
    input  logic   stop_req,
    input  logic   osc_hold_cfg,
    input  logic   ext_irq,
    input  logic   gen_irq,
    input  logic   gen_irq_en,
    input  logic   tick_irq,
    input  logic   dbg_irq,
    input  logic   mask_wr,
    input  logic   mask_wdata,
    input  logic   dbg_flag_clr,
    input  logic   settle_done,
    output pmode_e mode,
    output logic   hold_q,
    output logic   irq_mask,
    output logic   dbg_stop_flag,
    output logic   settle_start,
    output logic   stop_clear
);
    typedef struct packed {
        pmode_e mode;
        logic   hold;
        logic   imask;
        logic   brk;
    } fsm_t;

    localparam fsm_t FSM_RST = '{mode: M_RUN, hold: 1'b0, imask: 1'b1, brk: 1'b0};

    fsm_t r_q, r_d;
    logic wait_wake, stop_wake;

    always_comb begin
        wait_wake    = ext_irq | tick_irq | dbg_irq | (gen_irq & gen_irq_en);
        stop_wake    = ext_irq | dbg_irq | (tick_irq & r_q.hold);
        r_d          = r_q;
        settle_start = 1'b0;
        stop_clear   = 1'b0;
        unique case (r_q.mode)
            M_RUN: begin
                if (mask_wr)      r_d.imask = mask_wdata;
                if (dbg_flag_clr) r_d.brk   = 1'b0;
                if (stop_req) begin
                    r_d.mode   = M_STOP;
                    r_d.imask  = 1'b0;
                    r_d.hold   = osc_hold_cfg;
                    stop_clear = ~osc_hold_cfg;
                end else if (wait_req) begin
                    r_d.mode  = M_WAIT;
                    r_d.imask = 1'b0;
                end
            end
            M_WAIT: begin
                if (wait_wake) r_d.mode = M_RUN;
            end
            M_STOP: begin
                if (dbg_irq) r_d.brk = 1'b1;
                if (stop_wake) begin
                    if (r_q.hold) begin
                        r_d.mode = M_RUN;
                    end else begin
                        r_d.mode     = M_SETTLE;
                        settle_start = 1'b1;
                    end
                end
            end
            M_SETTLE: begin
                if (settle_done) r_d.mode = M_RUN;
            end
            default: r_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= FSM_RST;
        else        r_q <= r_d;
    end

    assign mode          = r_q.mode;
    assign hold_q        = r_q.hold;
    assign irq_mask      = r_q.imask;
    assign dbg_stop_flag = r_q.brk;

    p_sleep_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == M_RUN && (wait_req || stop_req)) |=> (r_q.mode != M_RUN && !r_q.imask));
    p_stop_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == M_RUN && stop_req) |=> (r_q.mode == M_STOP));
    p_mask_low_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode != M_RUN) |-> !r_q.imask);
    p_tick_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == M_STOP && r_q.hold && tick_irq) |=> (r_q.mode == M_RUN));
    p_gen_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == M_STOP && gen_irq && !ext_irq && !dbg_irq && !tick_irq) |=> (r_q.mode == M_STOP));
    p_brk_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == M_STOP && dbg_irq) |=> r_q.brk);
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int             CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } tmr_t;

    localparam tmr_t TMR_RST = '{act: 1'b0, cnt: '0};

    tmr_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        done = r_q.act && (r_q.cnt == LAST);
        if (start) begin
            r_d.act = 1'b1;
            r_d.cnt = '0;
        end else if (r_q.act) begin
            if (done) begin
                r_d.act = 1'b0;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= TMR_RST;
        else        r_q <= r_d;
    end

    p_settle_begin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (r_q.act && r_q.cnt == '0));
    p_settle_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.act |-> (r_q.cnt <= LAST));
endmodule

// File: rtl/lpm_cg_regs.sv
module lpm_cg_regs #(
    parameter int SET_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_run,
    input  logic             gen_off,
    input  logic             stop_clear,
    input  logic             xtal_ready,
    input  logic             rc_ready,
    input  logic             set_wr,
    input  logic [SET_W-1:0] set_wdata,
    input  logic             mon_wr,
    input  logic [1:0]       mon_wdata,
    input  logic             mon_fault,
    output logic             xtal_stable,
    output logic             rc_stable,
    output logic             mon_en,
    output logic             mon_irq_en,
    output logic             mon_flag,
    output logic [SET_W-1:0] gen_settings
);
    typedef struct packed {
        logic             xst;
        logic             rst;
        logic             men;
        logic             mie;
        logic             mfl;
        logic [SET_W-1:0] set;
    } cg_t;

    localparam cg_t CG_RST = '{xst: 1'b0, rst: 1'b0, men: 1'b0, mie: 1'b0, mfl: 1'b0, set: '0};

    cg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!gen_off) begin
            if (xtal_ready) r_d.xst = 1'b1;
            if (rc_ready)   r_d.rst = 1'b1;
        end
        if (cpu_run && set_wr) r_d.set = set_wdata;
        if (cpu_run && mon_wr) begin
            r_d.men = mon_wdata[0];
            r_d.mie = mon_wdata[1] & mon_wdata[0];
            r_d.mfl = 1'b0;
        end else if (mon_fault && r_q.men) begin
            r_d.mfl = 1'b1;
        end
        if (stop_clear) begin
            r_d.xst = 1'b0;
            r_d.rst = 1'b0;
            r_d.men = 1'b0;
            r_d.mie = 1'b0;
            r_d.mfl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CG_RST;
        else        r_q <= r_d;
    end

    assign xtal_stable  = r_q.xst;
    assign rc_stable    = r_q.rst;
    assign mon_en       = r_q.men;
    assign mon_irq_en   = r_q.mie;
    assign mon_flag     = r_q.mfl;
    assign gen_settings = r_q.set;

    p_stop_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clear && !set_wr) |=> (!r_q.xst && !r_q.rst && !r_q.men && !r_q.mie && !r_q.mfl
                                     && $stable(r_q.set)));
    p_mon_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.men |-> (!r_q.mie && !r_q.mfl));
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
    import lpm_pkg::*;
#(
    parameter int NCLK = 4
) (
    input  pmode_e          mode,
    input  logic            hold_q,
    output logic            cpu_clk_en,
    output logic [NCLK-1:0] clk_en
);
    logic gen_dark;

    always_comb begin
        cpu_clk_en = (mode == M_RUN);
        gen_dark   = (mode == M_SETTLE) || (mode == M_STOP && !hold_q);
    end

    for (genvar g = 0; g < NCLK; g++) begin : g_out
        assign clk_en[g] = ~gen_dark;
    end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4096,
    parameter int SET_W         = 16,
    parameter int NCLK          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_req,
    input  logic             stop_req,
    input  logic             osc_hold_cfg,
    input  logic             ext_irq,
    input  logic             gen_irq,
    input  logic             gen_irq_en,
    input  logic             tick_irq,
    input  logic             dbg_irq,
    input  logic             mask_wr,
    input  logic             mask_wdata,
    input  logic             dbg_flag_clr,
    input  logic             xtal_ready,
    input  logic             rc_ready,
    input  logic             set_wr,
    input  logic [SET_W-1:0] set_wdata,
    input  logic             mon_wr,
    input  logic [1:0]       mon_wdata,
    input  logic             mon_fault,
    output logic             cpu_clk_en,
    output logic [NCLK-1:0]  clk_en,
    output logic             irq_mask,
    output logic             dbg_stop_flag,
    output logic             xtal_stable,
    output logic             rc_stable,
    output logic             mon_en,
    output logic             mon_irq_en,
    output logic             mon_flag,
    output logic [SET_W-1:0] gen_settings,
    output logic [1:0]       mode
);
    pmode_e mode_w;
    logic   hold_w, settle_start, settle_done, stop_clear, gen_off, cpu_run;

    lpm_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wait_req     (wait_req),
        .stop_req     (stop_req),
        .osc_hold_cfg (osc_hold_cfg),
        .ext_irq      (ext_irq),
        .gen_irq      (gen_irq),
        .gen_irq_en   (gen_irq_en),
        .tick_irq     (tick_irq),
        .dbg_irq      (dbg_irq),
        .mask_wr      (mask_wr),
        .mask_wdata   (mask_wdata),
        .dbg_flag_clr (dbg_flag_clr),
        .settle_done  (settle_done),
        .mode         (mode_w),
        .hold_q       (hold_w),
        .irq_mask     (irq_mask),
        .dbg_stop_flag(dbg_stop_flag),
        .settle_start (settle_start),
        .stop_clear   (stop_clear)
    );

    lpm_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(settle_start),
        .done (settle_done)
    );

    assign cpu_run = (mode_w == M_RUN);
    assign gen_off = (mode_w == M_STOP) && !hold_w;

    lpm_cg_regs #(.SET_W(SET_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_run     (cpu_run),
        .gen_off     (gen_off),
        .stop_clear  (stop_clear),
        .xtal_ready  (xtal_ready),
        .rc_ready    (rc_ready),
        .set_wr      (set_wr),
        .set_wdata   (set_wdata),
        .mon_wr      (mon_wr),
        .mon_wdata   (mon_wdata),
        .mon_fault   (mon_fault),
        .xtal_stable (xtal_stable),
        .rc_stable   (rc_stable),
        .mon_en      (mon_en),
        .mon_irq_en  (mon_irq_en),
        .mon_flag    (mon_flag),
        .gen_settings(gen_settings)
    );

    lpm_clk_gate #(.NCLK(NCLK)) u_gate (
        .mode      (mode_w),
        .hold_q    (hold_w),
        .cpu_clk_en(cpu_clk_en),
        .clk_en    (clk_en)
    );

    assign mode = mode_w;

    p_clocks_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clear |=> (clk_en == '0 && !cpu_clk_en));
    p_hold_lit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && stop_req && osc_hold_cfg) |=> (clk_en == '1));
endmodule

// File: tb/tb_lpm_clk_ctrl.sv
module tb_lpm_clk_ctrl;
    localparam int SETTLE = 4096;
    localparam int SW     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_req = 0, stop_req = 0, osc_hold_cfg = 0, ext_irq = 0, gen_irq = 0, gen_irq_en = 0;
    logic tick_irq = 0, dbg_irq = 0, mask_wr = 0, mask_wdata = 0, dbg_flag_clr = 0;
    logic xtal_ready = 0, rc_ready = 0, set_wr = 0, mon_wr = 0, mon_fault = 0;
    logic [SW-1:0] set_wdata = '0;
    logic [1:0]    mon_wdata = '0;
    logic          cpu_clk_en, irq_mask, dbg_stop_flag, xtal_stable, rc_stable;
    logic          mon_en, mon_irq_en, mon_flag;
    logic [3:0]    clk_en;
    logic [SW-1:0] gen_settings;
    logic [1:0]    mode;

    always #10 clk = ~clk;

    lpm_clk_ctrl #(.SETTLE_CYCLES(SETTLE), .SET_W(SW), .NCLK(4)) dut (.*);

    int errors = 0;
    int checks = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_mode, m_mask, m_hold, m_brk, m_xs, m_rs, m_men, m_mie, m_mfl, m_set, m_cnt;
    bit m_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_mask = 1; m_hold = 0; m_brk = 0; m_xs = 0; m_rs = 0;
            m_men = 0; m_mie = 0; m_mfl = 0; m_set = 0; m_cnt = 0; m_valid = 1;
        end else begin
            int nm;
            bit dark;
            nm   = m_mode;
            dark = (m_mode == 2 && m_hold == 0);
            if (!dark && xtal_ready) m_xs = 1;
            if (!dark && rc_ready)   m_rs = 1;
            if (m_mode == 0 && mon_wr) begin
                m_men = mon_wdata[0];
                m_mie = mon_wdata[0] & mon_wdata[1];
                m_mfl = 0;
            end else if (mon_fault && m_men == 1) m_mfl = 1;
            if (m_mode == 0) begin
                if (set_wr)       m_set = set_wdata;
                if (mask_wr)      m_mask = mask_wdata;
                if (dbg_flag_clr) m_brk = 0;
                if (stop_req) begin
                    nm = 2; m_mask = 0; m_hold = osc_hold_cfg;
                    if (!osc_hold_cfg) begin
                        m_xs = 0; m_rs = 0; m_men = 0; m_mie = 0; m_mfl = 0;
                    end
                end else if (wait_req) begin
                    nm = 1; m_mask = 0;
                end
            end else if (m_mode == 1) begin
                if (ext_irq || tick_irq || dbg_irq || (gen_irq && gen_irq_en)) nm = 0;
            end else if (m_mode == 2) begin
                if (dbg_irq) m_brk = 1;
                if (ext_irq || dbg_irq || (tick_irq && m_hold == 1)) begin
                    nm = m_hold ? 0 : 3;
                    m_cnt = 0;
                end
            end else begin
                m_cnt++;
                if (m_cnt == SETTLE) nm = 0;
            end
            m_mode = nm;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_valid) begin
            bit dark;
            dark = (m_mode == 3) || (m_mode == 2 && m_hold == 0);
            chk("R1 cpu_clk_en", cpu_clk_en, m_mode == 0);
            chk("R1 mode", mode, m_mode);
            chk("R11 irq_mask", irq_mask, m_mask);
            chk("R4 clk_en", clk_en, dark ? 0 : 15);
            chk("R8 dbg_stop_flag", dbg_stop_flag, m_brk);
            chk("R5 xtal_stable", xtal_stable, m_xs);
            chk("R5 rc_stable", rc_stable, m_rs);
            chk("R10 mon_en", mon_en, m_men);
            chk("R10 mon_irq_en", mon_irq_en, m_mie);
            chk("R10 mon_flag", mon_flag, m_mfl);
            chk("R5 gen_settings", gen_settings, m_set);
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_set(ref logic s);
        s = 1'b1; tick(); s = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        tick();
        do_reset();
        // R2 reset state
        chk("R2 reset mode", mode, 0);
        chk("R2 reset mask", irq_mask, 1);
        chk("R2 reset clocks", clk_en, 15);
        chk("R2 reset cpu clk", cpu_clk_en, 1);

        // R10 setup of generator registers
        set_wdata = 16'hA5C3; pulse_set(set_wr);
        mon_wdata = 2'b10; pulse_set(mon_wr);
        chk("R10 irq_en needs enable", mon_irq_en, 0);
        mon_wdata = 2'b11; pulse_set(mon_wr);
        pulse_set(xtal_ready); pulse_set(rc_ready); pulse_set(mon_fault);
        chk("R10 flag set", mon_flag, 1);
        chk("R10 xtal stable", xtal_stable, 1);

        // R1/R3 wait and wake sources
        pulse_set(wait_req);
        chk("R1 wait cpu off", cpu_clk_en, 0);
        chk("R1 wait mask", irq_mask, 0);
        mask_wdata = 1; pulse_set(mask_wr);
        chk("R11 mask write ignored in wait", irq_mask, 0);
        gen_irq_en = 0; pulse_set(gen_irq);
        chk("R3 gen irq disabled no wake", mode, 1);
        gen_irq_en = 1; pulse_set(gen_irq);
        chk("R3 gen irq wakes wait", mode, 0);
        chk("R2 mask stays clear after wake", irq_mask, 0);
        pulse_set(mask_wr);
        chk("R11 mask write in run", irq_mask, 1);
        pulse_set(wait_req); pulse_set(tick_irq);
        chk("R3 tick wakes wait", mode, 0);
        pulse_set(dbg_irq);
        chk("R8 break in run no flag", dbg_stop_flag, 0);

        // R6/R7 stop with generator held
        osc_hold_cfg = 1; wait_req = 1; stop_req = 1; tick(); wait_req = 0; stop_req = 0;
        chk("R1 stop priority", mode, 2);
        chk("R6 clocks kept", clk_en, 15);
        chk("R6 stable kept", xtal_stable, 1);
        pulse_set(gen_irq);
        chk("R7 gen irq no stop wake", mode, 2);
        pulse_set(tick_irq);
        chk("R6 tick wakes at once", cpu_clk_en, 1);

        // R4/R5/R7/R8/R9 stop with generator off
        osc_hold_cfg = 0; pulse_set(stop_req);
        chk("R4 clocks low", clk_en, 0);
        chk("R5 xtal cleared", xtal_stable, 0);
        chk("R5 monitor cleared", mon_en + mon_irq_en + mon_flag, 0);
        chk("R5 settings kept", gen_settings, 16'hA5C3);
        pulse_set(tick_irq); pulse_set(gen_irq); pulse_set(xtal_ready);
        chk("R7 tick ignored", mode, 2);
        chk("R5 ready ignored while off", xtal_stable, 0);
        dbg_irq = 1; tick(); dbg_irq = 0;
        chk("R8 break sets flag", dbg_stop_flag, 1);
        n = 0;
        while (cpu_clk_en == 0 && n < SETTLE + 10) begin
            n++;
            chk("R4 clocks low while settling", clk_en, 0);
            tick();
        end
        chk("R9 settle length", n, SETTLE);
        chk("R9 back in run", mode, 0);

        // R8 flag untouched by stop entry
        pulse_set(dbg_flag_clr);
        chk("R8 flag cleared", dbg_stop_flag, 0);
        pulse_set(stop_req);
        chk("R8 stop entry keeps flag", dbg_stop_flag, 0);
        pulse_set(ext_irq);
        chk("R9 settling entered", mode, 3);
        tick(SETTLE);
        chk("R9 run after settle", mode, 0);
        chk("R8 flag still clear", dbg_stop_flag, 0);

        // R2 reset from wait
        pulse_set(wait_req);
        do_reset();
        chk("R2 reset from wait mode", mode, 0);
        chk("R2 reset sets mask", irq_mask, 1);
        chk("R2 reset settings", gen_settings, 0);
        tick(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule